// File: doc/BRIEF.md
# Self-Stopping Binary Down Counter

A four-bit synchronous counter that steps downward by one on each rising clock edge while its enable is high. It begins at 1111 after reset and passes through 15, 14, 13 and onward. When the value 0110 (decimal 6) appears, the counter halts and stays there. It does not pass through 5..0 and does not wrap back to 15.

Each bit is a toggle stage of a down counter. The least significant stage toggles on every enabled edge. Each higher stage toggles only when every stage below it reads zero, which is the borrow condition. Stop detection puts the least significant stage into hold. Every higher stage is qualified by that stage's toggle, so the whole word freezes together.

An active-low synchronous reset loads 1111 and clears the halted state. A `stopped` flag is high, combinationally, whenever the count is 0110.

Top module: `sdc_down_counter`

## Requirements
- R1: When `rst_n` is low at a rising edge, the count becomes 1111 and `stopped` reads 0 after that edge.
- R2: With `rst_n` high, `cnt_en` high and the count not equal to 0110, each rising edge lowers the count by exactly one.
- R3: `stopped` is 1 exactly when `count` equals 4'b0110, where `count[0]` is the least significant bit. It is 0 for every other value.
- R4: Once the count is 0110, further rising edges leave it at 0110 until reset, with `cnt_en` either high or low.
- R5: With `cnt_en` low, a rising edge leaves the count unchanged.
- R6: A reset applied while halted, or while in the middle of counting, restarts the sequence at 1111. Counting then resumes downward.
- R7: On an enabled, non-halted edge, bit 0 toggles. A higher bit changes only on an edge where every lower bit was 0.
- R8: After reset, the count never takes a value below 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low; presets the count to 1111 |
| cnt_en | input | 1 | Count enable; high lets the counter step |
| count | output | 4 | Present count; bit 0 is the LSB |
| stopped | output | 1 | High while the count equals 0110 |

## Verification
The first pattern holds the enable high from reset all the way to the halt. It compares every value from 15 down to 6 against the expected value, which separates a correct borrow chain from one that skips or repeats a code. The second pattern keeps the enable high for many edges after the halt. This separates a real stop from a design that wraps through 5..0 or returns to 15. The third pattern interleaves enable-low gaps with enable-high steps, which separates hold behaviour from free-running counting. The last two patterns apply reset, once from the halted state and once in mid-count, and confirm that counting restarts cleanly at 15.

// File: rtl/sdc_pkg.sv
// Package sdc_pkg
// Shared constants for the self-stopping down counter.
// Assumes a fixed stop code; the width is kept as a constant so derived values follow it.
package sdc_pkg;
    localparam int unsigned CNT_W = 4;
    localparam logic [CNT_W-1:0] PRESET_CODE = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] HALT_CODE = 4'b0110;
    typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/sdc_toggle_stage.sv
// Module sdc_toggle_stage
// One toggle flip-flop stage with a synchronous active-low preset to 1.
// Assumes tgl is a registered-domain signal that is stable before the rising edge.
module sdc_toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic tgl,
    output logic q
);
    // Purpose: preset on reset, otherwise invert when told to toggle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b1;
        else if (tgl)
            q <= ~q;
    end

    // R7: a requested toggle must flip the stage, and no request must keep it.
    p_toggle_flip_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tgl |=> (q != $past(q)));
    p_toggle_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tgl |=> $stable(q));
endmodule

// File: rtl/sdc_halt_detect.sv
// Module sdc_halt_detect
// Compares the count with the fixed halt code and raises the halt flag.
// Purely combinational; assumes count is the registered counter value.
module sdc_halt_detect
    import sdc_pkg::*;
(
    input  cnt_t count,
    output logic halt
);
    // Purpose: flag the terminal code.
    always_comb begin
        halt = (count == HALT_CODE);
    end
endmodule

// File: rtl/sdc_borrow_chain.sv
// Module sdc_borrow_chain
// Builds each stage's toggle request for down counting.
// The LSB request is gated by the halt flag, and every higher request is
// qualified by the LSB request, so a held LSB freezes the whole word.
module sdc_borrow_chain
    import sdc_pkg::*;
(
    input  logic cnt_en,
    input  logic halt,
    input  cnt_t count,
    output cnt_t tgl
);
    localparam int unsigned W = CNT_W;

    // Purpose: LSB steps unless halted or disabled; bit i steps when all lower bits borrow.
    always_comb begin
        logic lower_zero;
        lower_zero = 1'b1;
        tgl[0] = cnt_en & ~halt;
        for (int i = 1; i < W; i++) begin
            lower_zero = lower_zero & ~count[i-1];
            tgl[i] = tgl[0] & lower_zero;
        end
    end
endmodule

// File: rtl/sdc_down_counter.sv
// Module sdc_down_counter
// Top of the self-stopping down counter: a row of toggle stages, a borrow
// chain and a halt detector. Assumes a single clock and a synchronous active-low reset.
module sdc_down_counter
    import sdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    output logic [CNT_W-1:0] count,
    output logic             stopped
);
    cnt_t q_vec;
    cnt_t tgl_vec;
    logic halt;

    sdc_halt_detect u_halt (
        .count (q_vec),
        .halt  (halt)
    );

    sdc_borrow_chain u_chain (
        .cnt_en (cnt_en),
        .halt   (halt),
        .count  (q_vec),
        .tgl    (tgl_vec)
    );

    for (genvar g = 0; g < CNT_W; g++) begin : g_stage
        sdc_toggle_stage u_stage (
            .clk   (clk),
            .rst_n (rst_n),
            .tgl   (tgl_vec[g]),
            .q     (q_vec[g])
        );
    end

    // Purpose: drive the outputs from the stage row and the detector.
    always_comb begin
        count   = q_vec;
        stopped = halt;
    end

    // R1: reset presets the count and clears the halt flag.
    p_reset_load_r1: assert property (@(posedge clk)
        !rst_n |=> (count == PRESET_CODE && !stopped));
    // R2: an enabled, running edge steps the count down by one.
    p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !stopped) |=> (count == cnt_t'($past(count) - 1'b1)));
    // R4: the halt state persists until reset.
    p_halt_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        stopped |=> (stopped && $stable(count)));
    // R5: a disabled edge holds the count.
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> $stable(count));
    // R8: the count never falls below the halt code.
    p_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (count >= HALT_CODE));
endmodule

// File: tb/tb_sdc_down_counter.sv
module tb_sdc_down_counter;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cnt_en = 1'b0;
    logic [3:0] count;
    logic       stopped;

    int n_run = 0;
    int n_fail = 0;

    sdc_down_counter dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (cnt_en),
        .count   (count),
        .stopped (stopped)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [3:0] exp_cnt, input logic exp_stop);
        n_run++;
        if (count !== exp_cnt || stopped !== exp_stop) begin
            n_fail++;
            $display("FAIL %s: count=%0d stopped=%0b expected count=%0d stopped=%0b",
                     req, count, stopped, exp_cnt, exp_stop);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        step(1);
        rst_n = 1'b1;
    endtask

    // R1: reset state
    task automatic t_reset();
        cnt_en = 1'b1;
        do_reset();
        chk("R1", 4'd15, 1'b0);
    endtask

    // R2, R3, R7: full descent 15 to 6
    task automatic t_descent();
        cnt_en = 1'b1;
        do_reset();
        for (int v = 14; v >= 6; v--) begin
            step(1);
            chk((v == 6) ? "R3" : "R2/R7", 4'(v), (v == 6));
        end
    endtask

    // R4, R8: stays halted with enable high or low
    task automatic t_freeze();
        cnt_en = 1'b1;
        for (int i = 0; i < 25; i++) begin
            step(1);
            chk("R4/R8", 4'd6, 1'b1);
        end
        cnt_en = 1'b0;
        step(3);
        chk("R4", 4'd6, 1'b1);
    endtask

    // R5: enable low holds
    task automatic t_hold();
        cnt_en = 1'b0;
        do_reset();
        step(5);
        chk("R5", 4'd15, 1'b0);
        cnt_en = 1'b1;
        step(3);
        chk("R2", 4'd12, 1'b0);
        cnt_en = 1'b0;
        step(4);
        chk("R5", 4'd12, 1'b0);
        cnt_en = 1'b1;
        step(4);
        chk("R7", 4'd8, 1'b0);
    endtask

    // R6: restart from halted and from mid-count
    task automatic t_restart();
        cnt_en = 1'b1;
        step(10);
        chk("R6", 4'd6, 1'b1);
        do_reset();
        chk("R6", 4'd15, 1'b0);
        step(2);
        chk("R6", 4'd13, 1'b0);
        do_reset();
        chk("R6", 4'd15, 1'b0);
        step(1);
        chk("R6", 4'd14, 1'b0);
    endtask

    initial begin
        t_reset();
        t_descent();
        t_freeze();
        t_hold();
        t_restart();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule